// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block controls the low-power state of a small two-stage pipelined microcontroller core. The core runs one instruction cycle per four oscillator clocks, and the block produces those four phases. When the core reports that it has executed a sleep instruction, the block stops the core clock at the next cycle boundary. It then waits for a rising edge on an external interrupt line whose source is enabled. On that edge it raises the interrupt flag, applies an oscillator start-up delay when a crystal-type oscillator is selected, and restarts the core clock.

After wake-up the instruction that was already fetched behind the sleep instruction, at sleep address + 1, always runs for one full instruction cycle. At the end of that cycle the block reads the global interrupt enable. If it is set, the block flushes the second prefetched instruction, loads the interrupt vector into the program counter, pushes sleep address + 2 as the return address and clears the global enable. If it is clear, nothing is emitted and execution continues in line at sleep address + 2.

If an enabled interrupt is already pending when the sleep instruction executes, the core never stops. It goes straight into the post-wake instruction cycle, with no start-up delay.

Top module: `sleep_wake_seq`

## Requirements
- R1: After reset, `core_clk_en` is 1, `q_phase` is 0, and `int_flag_set`, `pc_load`, `flush`, `stack_push` and `gie_clr` are all 0.
- R2: While `core_clk_en` is 1, `q_phase` steps 0,1,2,3,0 on each clock. Value 3 is the last phase of an instruction cycle. `sleep_exec` is sampled only in a clock where `q_phase` is 3, and a pulse at any other phase has no effect.
- R3: A `sleep_exec` at phase 3 with no pending enabled interrupt drops `core_clk_en` from the next clock. `q_phase` then holds at 0 until the core wakes.
- R4: While asleep, a 0-to-1 change of `int_pin` with `int_en` = 1 pulses `int_flag_set` for exactly one clock, in the same clock as the edge. With `int_en` = 0 the edge is ignored and the core stays asleep.
- R5: With `osc_rc` = 0 (crystal-type), `core_clk_en` stays 0 for the next 1024 clocks after the `int_flag_set` clock and returns to 1 on the 1025th.
- R6: With `osc_rc` = 1, `core_clk_en` returns to 1 on the clock right after `int_flag_set`.
- R7: After wake-up, one full instruction cycle runs with phase 0 first. If `gie` is 1 in its phase-3 clock, then `pc_load`, `flush`, `stack_push` and `gie_clr` pulse together for that one clock, with `pc_target` = 0x0004 and `push_addr` = `sleep_pc` + 2.
- R8: If `gie` is 0 in that phase-3 clock, none of `pc_load`, `flush`, `stack_push` or `gie_clr` is asserted, and the core keeps running.
- R9: If `int_flag` and `int_en` are both 1 at the sampled `sleep_exec`, `core_clk_en` never drops and `int_flag_set` does not pulse. The post-wake cycle of R7/R8 follows at once.
- R10: The wake event is an edge. If `int_pin` is already 1 when sleep begins, it does not wake the core until the pin goes to 0 and then back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_exec | input | 1 | Core has executed a sleep instruction (sampled at phase 3) |
| sleep_pc | input | AW | Address of the sleep instruction, sampled with `sleep_exec` |
| int_pin | input | 1 | External interrupt line, rising-edge active |
| int_en | input | 1 | External interrupt source enable |
| int_flag | input | 1 | Current external interrupt flag held in the core |
| gie | input | 1 | Global interrupt enable |
| osc_rc | input | 1 | 1 = RC oscillator (no start-up delay), 0 = crystal-type |
| core_clk_en | output | 1 | Core clock enable |
| q_phase | output | 2 | Instruction-cycle phase, 0..3 |
| int_flag_set | output | 1 | Set the external interrupt flag |
| pc_load | output | 1 | Load `pc_target` into the program counter |
| pc_target | output | AW | Interrupt vector address while `pc_load` is 1, else 0 |
| flush | output | 1 | Discard the prefetched instruction |
| stack_push | output | 1 | Push `push_addr` onto the return stack |
| push_addr | output | AW | Return address (sleep address + 2) |
| gie_clr | output | 1 | Clear the global interrupt enable |

## Verification
The bench targets the exact length of the crystal start-up window. A counter that is off by one would bring `core_clk_en` back a clock early or late, and RC mode would show any wrongly added delay. It confirms that the sleep-address + 1 cycle always runs before the vector decision. A design that vectors immediately would load the PC at the wrong phase, and one that ignores `gie` would flush or push when execution should continue in line. It also covers three cases where the core must not sleep or wake: a pending interrupt at sleep time (a faulty design would stop the clock), a disabled source or a pin held high (a faulty design would wake on a level), and a `sleep_exec` pulse away from phase 3 (a faulty design would stop mid-cycle).

// File: rtl/sleepseq_pkg.sv
// Shared types for the sleep wake-up sequencer.
// Assumes: one controller instance per core; all state lives on the raw clock.
package sleepseq_pkg;

    // Controller states: running, stopped, oscillator settling, post-wake cycle
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DOZE  = 2'd1,
        ST_OST   = 2'd2,
        ST_POST  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sleepseq_phase.sv
// Instruction-cycle phase generator.
// Counts PHASES raw clocks per instruction cycle while enabled, and flags
// the last phase as the cycle boundary. It freezes while disabled.
// Assumes: it is disabled only right after a boundary, so it freezes at 0.
module sleepseq_phase #(
    parameter int PHASES = 4,
    localparam int QW    = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [QW-1:0] q,
    output logic          boundary
);

    localparam logic [QW-1:0] LAST = QW'(PHASES - 1);

    // Phase register: advance while the core clock runs, wrap after LAST
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= (q == LAST) ? '0 : q + 1'b1;
        end
    end

    // Boundary marker: the final phase of a running instruction cycle
    always_comb begin
        boundary = en && (q == LAST);
    end

endmodule

// File: rtl/sleepseq_ost.sv
// Oscillator start-up timer.
// Counts raw clocks while run is high and raises done in the COUNT-th clock.
// Held at zero while run is low. COUNT <= 1 selects a bypass with no counter.
module sleepseq_ost #(
    parameter int COUNT = 1024,
    localparam int CW   = $clog2(COUNT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    generate
        if (COUNT <= 1) begin : g_bypass
            // Bypass: the settle window is one clock at most
            always_comb begin
                done = run;
            end
        end else begin : g_count
            logic [CW-1:0] cnt;

            // Settle counter: cleared while idle, counts up while running
            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (!done) begin
                    cnt <= cnt + 1'b1;
                end
            end

            // Terminal count reached in this clock
            always_comb begin
                done = run && (cnt == CW'(COUNT - 1));
            end
        end
    endgenerate

endmodule

// File: rtl/sleepseq_edge.sv
// Rising-edge detector for the external interrupt line.
// Tracks the previous pin level on every clock and reports a 0-to-1 change
// only while armed.
// Assumes: the pin is already synchronous to clk.
module sleepseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic arm,
    output logic rise
);

    logic pin_q;

    // Previous pin level, updated on every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= pin;
        end
    end

    // Edge report gated by arm
    always_comb begin
        rise = arm && pin && !pin_q;
    end

endmodule

// File: rtl/sleepseq_ctrl.sv
// Sleep/wake state machine.
// Decides on cycle boundaries whether to stop the core. It waits for the
// wake event, routes through the start-up timer in crystal mode and runs
// one post-wake instruction cycle. Then it either vectors or continues in line.
// Assumes: sleep_pc is valid with sleep_exec, and gie is stable during the
// post-wake cycle.
module sleepseq_ctrl
    import sleepseq_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          sleep_exec,
    input  logic [AW-1:0] sleep_pc,
    input  logic          pend_flag,
    input  logic          src_en,
    input  logic          pin_rise,
    input  logic          rc_mode,
    input  logic          settle_done,
    input  logic          gie,
    output seq_state_t    state,
    output logic          wake_evt,
    output logic          vec_take,
    output logic [AW-1:0] ret_addr
);

    seq_state_t nxt;
    logic       take_sleep;

    // Sleep is recognised only at the end of an instruction cycle
    always_comb begin
        take_sleep = (state == ST_RUN) && boundary && sleep_exec;
        wake_evt   = (state == ST_DOZE) && pin_rise && src_en;
        vec_take   = (state == ST_POST) && boundary && gie;
    end

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:  if (take_sleep)  nxt = (pend_flag && src_en) ? ST_POST : ST_DOZE;
            ST_DOZE: if (wake_evt)    nxt = rc_mode ? ST_POST : ST_OST;
            ST_OST:  if (settle_done) nxt = ST_POST;
            ST_POST: if (boundary)    nxt = ST_RUN;
            default:                  nxt = ST_RUN;
        endcase
    end

    // State and return-address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            ret_addr <= '0;
        end else begin
            state <= nxt;
            if (take_sleep) begin
                ret_addr <= sleep_pc + AW'(2);
            end
        end
    end

endmodule

// File: rtl/sleep_wake_seq.sv
// Sleep wake-up sequencer top level.
// Joins the phase generator, the edge detector, the start-up timer and the
// controller, and turns controller state into core-facing strobes.
// Assumes: all inputs are synchronous to the raw oscillator clock.
module sleep_wake_seq
    import sleepseq_pkg::*;
#(
    parameter int          AW          = 13,
    parameter int          PHASES      = 4,
    parameter int          OST_CYCLES  = 1024,
    parameter logic [AW-1:0] VEC_ADDR  = AW'(4),
    localparam int         QW          = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_exec,
    input  logic [AW-1:0] sleep_pc,
    input  logic          int_pin,
    input  logic          int_en,
    input  logic          int_flag,
    input  logic          gie,
    input  logic          osc_rc,
    output logic          core_clk_en,
    output logic [QW-1:0] q_phase,
    output logic          int_flag_set,
    output logic          pc_load,
    output logic [AW-1:0] pc_target,
    output logic          flush,
    output logic          stack_push,
    output logic [AW-1:0] push_addr,
    output logic          gie_clr
);

    seq_state_t    state;
    logic          boundary;
    logic          pin_rise;
    logic          settle_done;
    logic          wake_evt;
    logic          vec_take;
    logic [AW-1:0] ret_addr;

    // Core clock runs in normal operation and during the post-wake cycle
    always_comb begin
        core_clk_en = (state == ST_RUN) || (state == ST_POST);
    end

    sleepseq_phase #(.PHASES(PHASES)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (core_clk_en),
        .q        (q_phase),
        .boundary (boundary)
    );

    sleepseq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (int_pin),
        .arm   (state == ST_DOZE),
        .rise  (pin_rise)
    );

    sleepseq_ost #(.COUNT(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_OST),
        .done  (settle_done)
    );

    sleepseq_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .sleep_exec  (sleep_exec),
        .sleep_pc    (sleep_pc),
        .pend_flag   (int_flag),
        .src_en      (int_en),
        .pin_rise    (pin_rise),
        .rc_mode     (osc_rc),
        .settle_done (settle_done),
        .gie         (gie),
        .state       (state),
        .wake_evt    (wake_evt),
        .vec_take    (vec_take),
        .ret_addr    (ret_addr)
    );

    // Core-facing strobes derived from the controller decisions
    always_comb begin
        int_flag_set = wake_evt;
        pc_load      = vec_take;
        flush        = vec_take;
        stack_push   = vec_take;
        gie_clr      = vec_take;
        pc_target    = vec_take ? VEC_ADDR : '0;
        push_addr    = ret_addr;
    end

endmodule

// File: rtl/sleep_wake_seq_chk.sv
// Property checker for the sleep wake-up sequencer, bound to every instance.
// It watches only the ports, plus a local counter that times the
// crystal start-up window.
module sleep_wake_seq_chk #(
    parameter int            AW         = 13,
    parameter int            OST_CYCLES = 1024,
    parameter logic [AW-1:0] VEC_ADDR   = AW'(4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gie,
    input logic          osc_rc,
    input logic          core_clk_en,
    input logic [1:0]    q_phase,
    input logic          int_flag_set,
    input logic          pc_load,
    input logic [AW-1:0] pc_target,
    input logic          flush,
    input logic          stack_push,
    input logic          gie_clr
);

    logic        xtal_armed;
    logic [31:0] dark_cnt;

    // Times the stopped window after a crystal-mode wake event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xtal_armed <= 1'b0;
            dark_cnt   <= '0;
        end else if (int_flag_set && !osc_rc) begin
            xtal_armed <= 1'b1;
            dark_cnt   <= '0;
        end else if (core_clk_en) begin
            xtal_armed <= 1'b0;
        end else if (xtal_armed) begin
            dark_cnt <= dark_cnt + 1;
        end
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |=> (q_phase == 2'($past(q_phase) + 2'd1)));

    // R3
    phase_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en |=> $stable(q_phase));

    // R4
    flag_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_flag_set |-> !core_clk_en);

    // R5
    xtal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag_set && !osc_rc) |=> !core_clk_en);

    // R5
    xtal_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(core_clk_en) && xtal_armed) |-> (dark_cnt == 32'(OST_CYCLES)));

    // R6
    rc_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_flag_set && osc_rc) |=> core_clk_en);

    // R7
    resume_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (q_phase == 2'd0));

    // R7
    vector_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (gie && flush && stack_push && gie_clr
                     && q_phase == 2'd3 && pc_target == VEC_ADDR));

    // R8
    no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || stack_push || gie_clr) |-> gie);

endmodule

bind sleep_wake_seq sleep_wake_seq_chk #(
    .AW         (AW),
    .OST_CYCLES (OST_CYCLES),
    .VEC_ADDR   (VEC_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gie          (gie),
    .osc_rc       (osc_rc),
    .core_clk_en  (core_clk_en),
    .q_phase      (q_phase),
    .int_flag_set (int_flag_set),
    .pc_load      (pc_load),
    .pc_target    (pc_target),
    .flush        (flush),
    .stack_push   (stack_push),
    .gie_clr      (gie_clr)
);

// File: tb/sleep_wake_seq_test.sv
// Self-checking bench for the sleep wake-up sequencer. It mixes directed
// corner cases with seeded random scenarios. Inputs change on the falling
// edge and outputs are sampled there as well.
module sleep_wake_seq_test;

    localparam int AW  = 13;
    localparam int OST = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_exec = 1'b0;
    logic [AW-1:0] sleep_pc = '0;
    logic          int_pin = 1'b0;
    logic          int_en = 1'b1;
    logic          int_flag = 1'b0;
    logic          gie = 1'b0;
    logic          osc_rc = 1'b0;
    logic          core_clk_en;
    logic [1:0]    q_phase;
    logic          int_flag_set;
    logic          pc_load;
    logic [AW-1:0] pc_target;
    logic          flush;
    logic          stack_push;
    logic [AW-1:0] push_addr;
    logic          gie_clr;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    sleep_wake_seq #(.AW(AW), .OST_CYCLES(OST)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .sleep_pc(sleep_pc),
        .int_pin(int_pin), .int_en(int_en), .int_flag(int_flag), .gie(gie),
        .osc_rc(osc_rc), .core_clk_en(core_clk_en), .q_phase(q_phase),
        .int_flag_set(int_flag_set), .pc_load(pc_load), .pc_target(pc_target),
        .flush(flush), .stack_push(stack_push), .push_addr(push_addr),
        .gie_clr(gie_clr)
    );

    always #10 clk = ~clk;

    // Expected model, taken from the requirements
    function automatic int exp_wake_delay(bit rc);
        return rc ? 1 : OST + 1;
    endfunction

    function automatic logic [AW-1:0] exp_ret(logic [AW-1:0] pc);
        return pc + AW'(2);
    endfunction

    function automatic logic [AW-1:0] exp_target(bit g);
        return g ? AW'(4) : AW'(0);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic to_boundary();
        forever begin
            @(negedge clk);
            if (core_clk_en && q_phase == 2'd3) break;
        end
    endtask

    // Issue a sleep at a cycle boundary; returns with the first post-sleep clock sampled
    task automatic go_sleep(logic [AW-1:0] pc, bit pending);
        to_boundary();
        sleep_exec = 1'b1;
        sleep_pc   = pc;
        int_flag   = pending;
        @(negedge clk);
        sleep_exec = 1'b0;
        int_flag   = 1'b0;
        if (pending) begin
            check(core_clk_en == 1'b1, "R9", "clk_en after pending sleep", core_clk_en, 1);
        end else begin
            check(core_clk_en == 1'b0, "R3", "clk_en after sleep", core_clk_en, 0);
        end
        check(q_phase == 2'd0, "R3", "phase after sleep", q_phase, 0);
    endtask

    // Run the post-wake instruction cycle, starting from its phase-0 sample
    task automatic post_cycle(bit g, logic [AW-1:0] pc);
        bit early = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (pc_load || flush || stack_push || gie_clr) early = 1'b1;
            @(negedge clk);
        end
        check(!early, "R7", "strobe before last phase", early, 0);
        check(q_phase == 2'd3, "R7", "phase at decision", q_phase, 3);
        check(pc_load == g && flush == g && stack_push == g && gie_clr == g,
              g ? "R7" : "R8", "vector strobes", {pc_load, flush, stack_push, gie_clr},
              g ? 15 : 0);
        check(pc_target == exp_target(g), g ? "R7" : "R8", "pc_target",
              pc_target, exp_target(g));
        if (g) check(push_addr == exp_ret(pc), "R7", "push_addr", push_addr, exp_ret(pc));
        @(negedge clk);
        check(core_clk_en && !pc_load && !flush, "R8", "running after decision",
              {core_clk_en, pc_load, flush}, 4);
    endtask

    // Raise the pin and follow the wake sequence
    task automatic wake(bit rc, bit g, logic [AW-1:0] pc);
        int d = exp_wake_delay(rc);
        bit early = 1'b0;
        osc_rc  = rc;
        gie     = g;
        int_pin = 1'b1;
        #1;
        check(int_flag_set == 1'b1, "R4", "flag on edge", int_flag_set, 1);
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            if (k < d && (core_clk_en || int_flag_set)) early = 1'b1;
        end
        check(!early, rc ? "R6" : "R5", "clock stayed off", early, 0);
        check(core_clk_en == 1'b1, rc ? "R6" : "R5", "clk_en at resume", core_clk_en, 1);
        check(q_phase == 2'd0, "R7", "resume phase", q_phase, 0);
        post_cycle(g, pc);
        int_pin = 1'b0;
    endtask

    initial begin
        #(150000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int seed = $urandom(32'd20240611);
        bit bad;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(core_clk_en == 1'b1 && q_phase == 2'd0, "R1", "reset clk_en/phase",
              {core_clk_en, q_phase}, 4);
        check(!int_flag_set && !pc_load && !flush && !stack_push && !gie_clr, "R1",
              "reset strobes", {int_flag_set, pc_load, flush, stack_push, gie_clr}, 0);
        rst_n = 1'b1;

        // R2: sleep_exec away from phase 3 is ignored
        forever begin
            @(negedge clk);
            if (q_phase == 2'd1) break;
        end
        sleep_exec = 1'b1;
        @(negedge clk);
        sleep_exec = 1'b0;
        bad = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (!core_clk_en) bad = 1'b1;
        end
        check(!bad, "R2", "clock kept running", bad, 0);

        // Directed: both modes, both gie values
        go_sleep(13'h0120, 1'b0); repeat (5) @(negedge clk); wake(1'b0, 1'b1, 13'h0120);
        go_sleep(13'h0200, 1'b0); repeat (3) @(negedge clk); wake(1'b0, 1'b0, 13'h0200);
        go_sleep(13'h1FFE, 1'b0); repeat (2) @(negedge clk); wake(1'b1, 1'b1, 13'h1FFE);
        go_sleep(13'h0033, 1'b0); repeat (4) @(negedge clk); wake(1'b1, 1'b0, 13'h0033);

        // R9: pending interrupt at sleep
        osc_rc = 1'b0; gie = 1'b1;
        go_sleep(13'h0444, 1'b1);
        check(int_flag_set == 1'b0, "R9", "no flag pulse", int_flag_set, 0);
        post_cycle(1'b1, 13'h0444);
        gie = 1'b0;
        go_sleep(13'h0555, 1'b1);
        post_cycle(1'b0, 13'h0555);

        // R4: disabled source is ignored
        go_sleep(13'h0700, 1'b0);
        int_en = 1'b0;
        @(negedge clk);
        int_pin = 1'b1;
        #1;
        check(int_flag_set == 1'b0, "R4", "flag with source off", int_flag_set, 0);
        bad = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (core_clk_en) bad = 1'b1;
        end
        check(!bad, "R4", "asleep with source off", bad, 0);
        int_pin = 1'b0;
        int_en  = 1'b1;
        @(negedge clk);
        wake(1'b1, 1'b1, 13'h0700);

        // R10: pin already high at sleep entry
        int_pin = 1'b1;
        go_sleep(13'h0010, 1'b0);
        bad = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (core_clk_en || int_flag_set) bad = 1'b1;
        end
        check(!bad, "R10", "level does not wake", bad, 0);
        int_pin = 1'b0;
        @(negedge clk);
        wake(1'b1, 1'b0, 13'h0010);

        // Seeded random scenarios
        for (int i = 0; i < 12; i++) begin
            bit rc   = 1'($urandom);
            bit g    = 1'($urandom);
            bit pend = ($urandom % 4) == 0;
            logic [AW-1:0] pc = AW'($urandom);
            int idle = 1 + ($urandom % 20);
            osc_rc = rc;
            gie    = g;
            go_sleep(pc, pend);
            if (pend) begin
                post_cycle(g, pc);
            end else begin
                repeat (idle) @(negedge clk);
                wake(rc, g, pc);
            end
            repeat ($urandom % 6) @(negedge clk);
        end

        if (seed == 0) $display("seed note");
        report();
    end

endmodule